// File: doc/BRIEF.md
# Pipelined Multi-Hit Priority Encoder

This block takes one 32-bit word per clock and reports where its four lowest set bits are. It does this with a chain of four registered find-and-clear stages. Each stage finds the lowest set bit in the word it receives and records that bit's index in its own result slot. It then clears that bit and hands the reduced word to the next stage. Because every stage is one register deep, a new word can enter on every clock. The four indices, each with a found flag, then leave the block together in a single output cycle.

The block is used wherever one word has to yield several set-bit positions at full line rate, for example to pick up to four requesters from a request vector. A bit-serial scan would need up to 32 clocks per word. This block trades that scan for four copies of a single-bit locator, which keeps one-word-per-clock throughput.

Top module: `mhpe_top`

## Requirements
- R1: The block accepts a 32-bit word `in_word`, qualified by `in_valid`, on every clock with no stall, including back-to-back valid words.
- R2: `out_valid` is asserted exactly four clocks after the clock edge that samples the matching `in_valid`, so that a word presented in cycle t appears in cycle t+4.
- R3: Bit 0 has the highest priority. Slot 0 reports the lowest set bit of the word and slot k reports the (k+1)-th lowest set bit, so the indices of the found slots increase strictly from slot 0 upward.
- R4: The found flags form a thermometer code from slot 0 upward, and their count equals the lesser of the word's set-bit count and four.
- R5: A slot whose found flag is clear shows index 0.
- R6: An all-zero word gives a valid output with all four found flags clear.
- R7: A synchronous active-high `rst` clears every pipeline stage. No `out_valid` appears until a word sampled after reset has passed through all four stages.
- R8: When a word has more than four set bits, the bits beyond the fourth have no effect on the output. For example, an all-ones word yields indices 0, 1, 2, 3.
- R9: `out_idx` packs slot k into bits [5k+4:5k] and `out_found[k]` is the flag of slot k.
- R10: A cycle with `in_valid` low produces a cycle with `out_valid` low four clocks later, so gaps in the input are kept in the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word qualifier |
| in_word | input | 32 | Word to be searched |
| out_valid | output | 1 | Result qualifier, four clocks after input |
| out_found | output | 4 | Per-slot found flag, slot 0 in bit 0 |
| out_idx | output | 20 | Four 5-bit indices, slot k in bits [5k+4:5k] |

## Verification
The main function is driven with:
- single-bit words at every position, which separate the index encoding and show whether the top bit is reached;
- an all-zero word;
- two- and three-bit words, where unused slots must read zero;
- words with many set bits, including all ones and the top four bits alone, where extra bits must be ignored and the upper slots must still be reached;
- a long run of pseudo-random words;
- streams with interleaved bubbles, which expose any misalignment between the index registers and the valid chain;
- a reset in the middle of a stream, which shows whether words already in flight are discarded.

// File: rtl/mhpe_pkg.sv
package mhpe_pkg;

    // Default geometry of the encoder.
    localparam int unsigned DEF_WORD_W   = 32;
    localparam int unsigned DEF_NUM_HITS = 4;

    // Number of bits needed to index a word of the given width.
    function automatic int unsigned idx_width(input int unsigned word_w);
        int unsigned w;
        w = 1;
        while ((1 << w) < word_w) begin
            w = w + 1;
        end
        return w;
    endfunction

endpackage

// File: rtl/mhpe_find_clear.sv
// Combinational locator: finds the lowest set bit, encodes its index and
// returns the word with that bit removed.
module mhpe_find_clear #(
    parameter int unsigned WORD_W = mhpe_pkg::DEF_WORD_W,
    parameter int unsigned IDX_W  = mhpe_pkg::idx_width(WORD_W)
) (
    input  logic [WORD_W-1:0] word_i,
    output logic              hit_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic [WORD_W-1:0] rest_o
);

    logic [WORD_W-1:0] lowest;

    always_comb begin
        // Two's complement isolates the lowest set bit.
        lowest = word_i & (~word_i + {{(WORD_W-1){1'b0}}, 1'b1});
        rest_o = word_i & ~lowest;
        hit_o  = |word_i;
        idx_o  = '0;
        for (int i = 0; i < int'(WORD_W); i++) begin
            if (lowest[i]) begin
                idx_o = idx_o | IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/mhpe_stage.sv
// One registered find-and-clear stage. It fills result slot SLOT and
// carries the slots already filled by earlier stages alongside the word.
module mhpe_stage #(
    parameter int unsigned WORD_W   = mhpe_pkg::DEF_WORD_W,
    parameter int unsigned NUM_HITS = mhpe_pkg::DEF_NUM_HITS,
    parameter int unsigned SLOT     = 0,
    parameter int unsigned IDX_W    = mhpe_pkg::idx_width(WORD_W)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      valid_i,
    input  logic [WORD_W-1:0]         word_i,
    input  logic [NUM_HITS-1:0]       found_i,
    input  logic [NUM_HITS*IDX_W-1:0] idx_i,
    output logic                      valid_o,
    output logic [WORD_W-1:0]         word_o,
    output logic [NUM_HITS-1:0]       found_o,
    output logic [NUM_HITS*IDX_W-1:0] idx_o
);

    typedef struct packed {
        logic                      valid;
        logic [WORD_W-1:0]         word;
        logic [NUM_HITS-1:0]       found;
        logic [NUM_HITS*IDX_W-1:0] idx;
    } stage_t;

    stage_t st_d, st_q;

    logic              hit;
    logic [IDX_W-1:0]  hit_idx;
    logic [WORD_W-1:0] rest;

    mhpe_find_clear #(
        .WORD_W(WORD_W),
        .IDX_W (IDX_W)
    ) u_find (
        .word_i(word_i),
        .hit_o (hit),
        .idx_o (hit_idx),
        .rest_o(rest)
    );

    always_comb begin
        st_d        = st_q;
        st_d.valid  = valid_i;
        st_d.word   = rest;
        st_d.found  = found_i;
        st_d.idx    = idx_i;
        st_d.found[SLOT] = hit;
        st_d.idx[SLOT*IDX_W +: IDX_W] = hit ? hit_idx : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o = st_q.valid;
    assign word_o  = st_q.word;
    assign found_o = st_q.found;
    assign idx_o   = st_q.idx;

endmodule

// File: rtl/mhpe_top.sv
module mhpe_top #(
    parameter int unsigned WORD_W   = mhpe_pkg::DEF_WORD_W,
    parameter int unsigned NUM_HITS = mhpe_pkg::DEF_NUM_HITS,
    parameter int unsigned IDX_W    = mhpe_pkg::idx_width(WORD_W)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    input  logic [WORD_W-1:0]         in_word,
    output logic                      out_valid,
    output logic [NUM_HITS-1:0]       out_found,
    output logic [NUM_HITS*IDX_W-1:0] out_idx
);

    localparam int unsigned PACK_W = NUM_HITS * IDX_W;

    logic                v_s [0:NUM_HITS];
    logic [WORD_W-1:0]   w_s [0:NUM_HITS];
    logic [NUM_HITS-1:0] f_s [0:NUM_HITS];
    logic [PACK_W-1:0]   i_s [0:NUM_HITS];

    assign v_s[0] = in_valid;
    assign w_s[0] = in_word;
    assign f_s[0] = '0;
    assign i_s[0] = '0;

    for (genvar s = 0; s < NUM_HITS; s++) begin : g_stage
        mhpe_stage #(
            .WORD_W  (WORD_W),
            .NUM_HITS(NUM_HITS),
            .SLOT    (s),
            .IDX_W   (IDX_W)
        ) u_stage (
            .clk    (clk),
            .rst    (rst),
            .valid_i(v_s[s]),
            .word_i (w_s[s]),
            .found_i(f_s[s]),
            .idx_i  (i_s[s]),
            .valid_o(v_s[s+1]),
            .word_o (w_s[s+1]),
            .found_o(f_s[s+1]),
            .idx_o  (i_s[s+1])
        );
    end

    assign out_valid = v_s[NUM_HITS];
    assign out_found = f_s[NUM_HITS];
    assign out_idx   = i_s[NUM_HITS];

endmodule

// File: rtl/mhpe_checker.sv
module mhpe_checker #(
    parameter int unsigned WORD_W   = mhpe_pkg::DEF_WORD_W,
    parameter int unsigned NUM_HITS = mhpe_pkg::DEF_NUM_HITS,
    parameter int unsigned IDX_W    = mhpe_pkg::idx_width(WORD_W)
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      in_valid,
    input logic [WORD_W-1:0]         in_word,
    input logic                      out_valid,
    input logic [NUM_HITS-1:0]       out_found,
    input logic [NUM_HITS*IDX_W-1:0] out_idx
);

    // Input history, one entry per pipeline stage.
    logic [NUM_HITS-1:0] hv;
    logic [WORD_W-1:0]   hw [NUM_HITS];

    always_ff @(posedge clk) begin
        if (rst) begin
            hv <= '0;
            for (int i = 0; i < int'(NUM_HITS); i++) hw[i] <= '0;
        end else begin
            hv[0] <= in_valid;
            hw[0] <= in_word;
            for (int i = 1; i < int'(NUM_HITS); i++) begin
                hv[i] <= hv[i-1];
                hw[i] <= hw[i-1];
            end
        end
    end

    logic [WORD_W-1:0] src;
    int unsigned       want_cnt;
    assign src      = hw[NUM_HITS-1];
    assign want_cnt = ($countones(src) > NUM_HITS) ? NUM_HITS : $countones(src);

    // R2 / R10: output valid follows input valid after the pipeline depth
    a_r2_latency: assert property (@(posedge clk) disable iff (rst)
        out_valid == hv[NUM_HITS-1]);

    // R7: nothing valid directly after a reset cycle
    a_r7_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_valid);

    // R4: number of found flags matches the source word
    a_r4_count: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $countones(out_found) == want_cnt);

    // R4: flags are a thermometer code from slot 0
    a_r4_thermo: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((out_found & (out_found + 1'b1)) == '0));

    // R6: empty word gives no hits
    a_r6_empty: assert property (@(posedge clk) disable iff (rst)
        (out_valid && src == '0) |-> out_found == '0);

    // R3: slot 0 is the lowest set bit of the source word
    a_r3_lowest: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_found[0]) |->
            (src[out_idx[IDX_W-1:0]] &&
             ((src & ((WORD_W'(1) << out_idx[IDX_W-1:0]) - 1'b1)) == '0)));

    for (genvar k = 0; k < NUM_HITS; k++) begin : g_slot
        // R5: unused slot reads index zero
        a_r5_unused_zero: assert property (@(posedge clk) disable iff (rst)
            (out_valid && !out_found[k]) |-> out_idx[k*IDX_W +: IDX_W] == '0);
        // R3: each reported index is a set bit of the source word
        a_r3_is_set: assert property (@(posedge clk) disable iff (rst)
            (out_valid && out_found[k]) |-> src[out_idx[k*IDX_W +: IDX_W]]);
        if (k > 0) begin : g_order
            // R3: indices increase strictly with slot number
            a_r3_order: assert property (@(posedge clk) disable iff (rst)
                (out_valid && out_found[k]) |->
                    out_idx[k*IDX_W +: IDX_W] > out_idx[(k-1)*IDX_W +: IDX_W]);
        end
    end

endmodule

bind mhpe_top mhpe_checker #(
    .WORD_W  (WORD_W),
    .NUM_HITS(NUM_HITS),
    .IDX_W   (IDX_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_word  (in_word),
    .out_valid(out_valid),
    .out_found(out_found),
    .out_idx  (out_idx)
);

// File: tb/mhpe_top_test.sv
module mhpe_top_test;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 4;

    typedef struct {
        bit        v;
        bit [31:0] w;
    } entry_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        out_valid;
    logic [3:0]  out_found;
    logic [19:0] out_idx;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    bit model_on = 1'b0;

    entry_t hist[$];

    mhpe_top uut (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_word  (in_word),
        .out_valid(out_valid),
        .out_found(out_found),
        .out_idx  (out_idx)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference: collect the four lowest set bits.
    task automatic expect_of(input bit [31:0] w, output bit [3:0] f, output bit [19:0] ix);
        int n;
        n = 0; f = '0; ix = '0;
        for (int b = 0; b < 32; b++) begin
            if (w[b] && n < 4) begin
                f[n] = 1'b1;
                ix[n*5 +: 5] = 5'(b);
                n++;
            end
        end
    endtask

    // Model input history at each sampling edge.
    always @(posedge clk) begin
        entry_t e;
        if (rst) begin
            foreach (hist[i]) hist[i].v = 1'b0;
            e.v = 1'b0;
        end else begin
            e.v = in_valid;
        end
        e.w = in_word;
        hist.push_back(e);
        if (hist.size() > DEPTH) void'(hist.pop_front());
    end

    // Compare on every falling edge.
    always @(negedge clk) begin
        if (model_on) begin
            bit        ev;
            bit [3:0]  ef;
            bit [19:0] ei;
            string     tag;
            ev = (hist.size() == DEPTH) ? hist[0].v : 1'b0;
            checks++;
            if (out_valid !== ev) begin
                errors++;
                $display("FAIL R2/R10 out_valid actual=%0b expected=%0b", out_valid, ev);
            end else if (ev) begin
                expect_of(hist[0].w, ef, ei);
                if (hist[0].w == '0) tag = "R6";
                else if ($countones(hist[0].w) > 4) tag = "R8";
                else tag = "R3";
                if (out_found !== ef) begin
                    errors++;
                    $display("FAIL R4 %s word=%h found actual=%b expected=%b", tag, hist[0].w, out_found, ef);
                end
                // R9 packing, R5 zero in unused slots
                if (out_idx !== ei) begin
                    errors++;
                    $display("FAIL %s R9 R5 word=%h idx actual=%h expected=%h", tag, hist[0].w, out_idx, ei);
                end
            end
        end
    end

    task automatic send(input bit v, input bit [31:0] w);
        in_valid = v;
        in_word  = w;
        @(negedge clk);
    endtask

    task automatic check_novalid(input string tag);
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL %s out_valid actual=%0b expected=0", tag, out_valid);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_novalid("R7");               // reset state
        rst = 1'b0;
        model_on = 1'b1;
        // R3: single bit at every position
        for (int b = 0; b < 32; b++) send(1'b1, 32'h1 << b);
        // R6: empty word, R8: overfull words
        send(1'b1, 32'h0);
        send(1'b1, 32'hFFFF_FFFF);
        send(1'b1, 32'hF000_0000);
        send(1'b1, 32'h8000_0001);
        send(1'b1, 32'h0001_0100);
        send(1'b1, 32'h4210_8421);
        send(1'b1, 32'h0000_0000);
        // R1: back-to-back valid random words
        for (int i = 0; i < 400; i++) send(1'b1, $urandom);
        // R10: bubbles interleaved
        for (int i = 0; i < 200; i++) send(i % 3 != 0, $urandom & $urandom);
        // R7: reset in mid stream discards words in flight
        for (int i = 0; i < 3; i++) send(1'b1, $urandom);
        rst = 1'b1; in_valid = 1'b1; in_word = 32'h0000_00F0;
        @(negedge clk);
        rst = 1'b0;
        check_novalid("R7");
        send(1'b1, 32'h0000_0003);
        check_novalid("R7");
        send(1'b1, 32'h0000_0005);
        check_novalid("R7");
        send(1'b1, 32'h0000_0009);
        send(1'b0, 32'h0);
        repeat (DEPTH + 2) send(1'b0, 32'h0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule